// File: doc/BRIEF.md
# Armed Sweep Gate Detect Latches

This block keeps two sticky status flags that record activity on the sweep gates of a display timebase. A host can read the flags later and clear them. The main-gate flag is set only by a complete low-then-high pulse edge of the main sweep gate, and only while the arming input is low. The delayed-gate flag is level sensitive. It is set whenever the delayed sweep gate is seen low.

One clear input serves both flags, and it acts on each in a different way. The main-gate flag is cleared once, on the clear's leading (active-going) transition. A main-gate event that happens while the clear is still held active is therefore recorded. The delayed-gate flag is held at zero for as long as the clear stays at its active level.

Every input is asynchronous. Each one passes through a synchronizer chain of `SYNC_STAGES` flops. Edges are then detected in the system clock domain.

The main latch is a Moore machine with three states:
- MG_WAIT_FALL: no falling edge has been seen yet.
- MG_PRIMED: a falling edge has been seen.
- MG_CAPTURED: the flag is set.

Its transitions are:
- ARM: on a falling edge, MG_WAIT_FALL goes to MG_PRIMED.
- CAPTURE: on a rising edge while armed, MG_PRIMED goes to MG_CAPTURED.
- DISCARD: on a rising edge while disarmed, MG_PRIMED goes back to MG_WAIT_FALL.
- WIPE: a clear leading edge sends any state to MG_WAIT_FALL. This transition has priority over all others.

The delayed latch has two states, DG_CLEAR and DG_SET:
- SET: DG_CLEAR goes to DG_SET when the gate is low and the clear is inactive.
- HOLD_CLEAR: any state goes to DG_CLEAR while the clear is active.

Top module: `sweep_gate_detect`

## Requirements
- R1: While `rst_n` is low, both `main_hit_o` and `dly_hit_o` read 0, whatever their state was before.
- R2: With `arm_n_i` low, a rising edge of `main_gate_i` that follows a falling edge sets `main_hit_o` to 1.
- R3: A rising edge of `main_gate_i` with no falling edge before it (since reset or since the last clear or capture) leaves `main_hit_o` at 0.
- R4: A rising edge that arrives while `arm_n_i` is high does not set `main_hit_o` and uses up the primed falling edge. A later capture then needs a new falling edge.
- R5: Once `main_hit_o` is 1, it stays 1 through any gate edges, arming changes and clear releases until a clear leading edge arrives.
- R6: The leading edge of `clr_i` (a high-to-low transition with the default `CLR_ACTIVE_LOW`=1) drives `main_hit_o` to 0. A falling edge seen before that clear is discarded. The release of the clear does not change `main_hit_o`.
- R7: While `clr_i` stays active after its leading edge, a falling edge followed by a rising edge with the latch armed still sets `main_hit_o`.
- R8: With `clr_i` inactive, `main_gate` aside, `dly_gate_i` at 0 sets `dly_hit_o` to 1. The flag stays 1 after `dly_gate_i` returns high.
- R9: `dly_hit_o` is held at 0 for as long as `clr_i` is active, even if `dly_gate_i` is low. It sets once the clear is released if `dly_gate_i` is still low.
- R10: If a clear leading edge and a capturing rising edge reach the synchronized domain in the same cycle, the clear wins and `main_hit_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| main_gate_i | input | 1 | Main sweep gate, asynchronous |
| dly_gate_i | input | 1 | Delayed sweep gate, asynchronous |
| arm_n_i | input | 1 | Arming input; the main latch may set only while this is low |
| clr_i | input | 1 | Shared latch clear; active level set by `CLR_ACTIVE_LOW` |
| main_hit_o | output | 1 | Main-gate detect flag |
| dly_hit_o | output | 1 | Delayed-gate detect flag |

## Verification
The main latch is driven with several patterns:
- A rise with no preceding fall, which shows that the machine needs the full fall-then-rise order.
- Fall-rise pairs with the arming input high and low, which separate the arming gate from the edge tracking.
- Falls seen just before a clear, which prove that the primed state is wiped.

The clear is exercised at its leading edge, while held active and at its release. These cases separate the edge-cleared main latch from the level-cleared delayed latch. A clear arriving in the same cycle as a capturing rise confirms that the clear has priority.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    // Main-gate latch states
    typedef enum logic [1:0] {
        MG_WAIT_FALL = 2'd0,
        MG_PRIMED    = 2'd1,
        MG_CAPTURED  = 2'd2
    } mg_state_t;

    // Delayed-gate latch states
    typedef enum logic {
        DG_CLEAR = 1'b0,
        DG_SET   = 1'b1
    } dg_state_t;

    // Bit positions inside the synchronized input bundle
    localparam int IDX_MAIN = 0;
    localparam int IDX_DLY  = 1;
    localparam int IDX_ARM  = 2;
    localparam int IDX_CLR  = 3;
    localparam int N_INPUTS = 4;

endpackage

// File: rtl/sgd_sync.sv
// Multi-flop synchronizer for one asynchronous input.
module sgd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sgd_edge.sv
// Edge detector over a vector of already-synchronized levels.
module sgd_edge #(
    parameter int             WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rose,
    output logic [WIDTH-1:0] fell
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    always_comb begin
        rose = lvl & ~prev_q;
        fell = ~lvl & prev_q;
    end
endmodule

// File: rtl/sgd_main_fsm.sv
// Main-gate detect latch: needs fall then rise while armed; wiped on clear edge.
module sgd_main_fsm
    import sgd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_rise,
    input  logic gate_fall,
    input  logic armed,
    input  logic clr_lead,
    output logic hit
);
    mg_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MG_WAIT_FALL;
        else        state_q <= state_d;
    end

    // Next-state logic; WIPE has priority over every other transition
    always_comb begin
        state_d = state_q;
        if (clr_lead) begin
            state_d = MG_WAIT_FALL;                    // WIPE
        end else begin
            unique case (state_q)
                MG_WAIT_FALL: if (gate_fall) state_d = MG_PRIMED;   // ARM
                MG_PRIMED: begin
                    if (gate_rise && armed)  state_d = MG_CAPTURED; // CAPTURE
                    else if (gate_rise)      state_d = MG_WAIT_FALL; // DISCARD
                end
                MG_CAPTURED:  state_d = MG_CAPTURED;
                default:      state_d = MG_WAIT_FALL;
            endcase
        end
    end

    // Output decode
    always_comb begin
        hit = (state_q == MG_CAPTURED);
    end
endmodule

// File: rtl/sgd_dly_fsm.sv
// Delayed-gate detect latch: level set, level held clear.
module sgd_dly_fsm
    import sgd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_low,
    input  logic clr_hold,
    output logic hit
);
    dg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_hold) begin
            state_d = DG_CLEAR;                        // HOLD_CLEAR
        end else begin
            unique case (state_q)
                DG_CLEAR: if (gate_low) state_d = DG_SET;   // SET
                DG_SET:   state_d = DG_SET;
                default:  state_d = DG_CLEAR;
            endcase
        end
    end

    always_comb begin
        hit = (state_q == DG_SET);
    end
endmodule

// File: rtl/sweep_gate_detect.sv
module sweep_gate_detect
    import sgd_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter bit CLR_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_gate_i,
    input  logic dly_gate_i,
    input  logic arm_n_i,
    input  logic clr_i,
    output logic main_hit_o,
    output logic dly_hit_o
);
    localparam logic CLR_IDLE = CLR_ACTIVE_LOW ? 1'b1 : 1'b0;
    // Reset levels chosen so no spurious edge or set appears while chains fill
    localparam logic [N_INPUTS-1:0] SYNC_RST = {CLR_IDLE, 1'b1, 1'b1, 1'b0};

    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] sync_lvl;
    logic [1:0]          edge_rose;
    logic [1:0]          edge_fell;
    logic                main_rise, main_fall;
    logic                armed, dly_low;
    logic                clr_act, clr_lead;

    assign raw_in = {clr_i, arm_n_i, dly_gate_i, main_gate_i};

    for (genvar g = 0; g < N_INPUTS; g++) begin : g_sync
        sgd_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(SYNC_RST[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_in[g]),
            .q    (sync_lvl[g])
        );
    end

    // Edges are needed only for the main gate (bit 0) and the clear (bit 1)
    sgd_edge #(
        .WIDTH  (2),
        .RST_VAL({CLR_IDLE, 1'b0})
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({sync_lvl[IDX_CLR], sync_lvl[IDX_MAIN]}),
        .rose (edge_rose),
        .fell (edge_fell)
    );

    assign main_rise = edge_rose[0];
    assign main_fall = edge_fell[0];
    assign armed     = ~sync_lvl[IDX_ARM];
    assign dly_low   = ~sync_lvl[IDX_DLY];

    if (CLR_ACTIVE_LOW) begin : g_clr_low
        assign clr_act  = ~sync_lvl[IDX_CLR];
        assign clr_lead = edge_fell[1];
    end else begin : g_clr_high
        assign clr_act  = sync_lvl[IDX_CLR];
        assign clr_lead = edge_rose[1];
    end

    sgd_main_fsm u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_rise(main_rise),
        .gate_fall(main_fall),
        .armed    (armed),
        .clr_lead (clr_lead),
        .hit      (main_hit_o)
    );

    sgd_dly_fsm u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_low(dly_low),
        .clr_hold(clr_act),
        .hit     (dly_hit_o)
    );
endmodule

module sgd_checker (
    input logic clk,
    input logic rst_n,
    input logic main_hit_o,
    input logic dly_hit_o,
    input logic main_rise,
    input logic armed,
    input logic dly_low,
    input logic clr_act,
    input logic clr_lead
);
    assert_set_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_hit_o) |-> $past(main_rise && armed));

    assert_disarmed_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rise && !armed && !main_hit_o) |=> !main_hit_o);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (main_hit_o && !clr_lead) |=> main_hit_o);

    // Covers R6 and the clear-priority rule R10
    assert_clear_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lead |=> !main_hit_o);

    assert_dly_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_low && !clr_act) |=> dly_hit_o);

    assert_dly_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> !dly_hit_o);
endmodule

bind sweep_gate_detect sgd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_hit_o(main_hit_o),
    .dly_hit_o (dly_hit_o),
    .main_rise (main_rise),
    .armed     (armed),
    .dly_low   (dly_low),
    .clr_act   (clr_act),
    .clr_lead  (clr_lead)
);

// File: tb/tb_sweep_gate_detect.sv
module tb_sweep_gate_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_gate = 1'b0;
    logic dly_gate = 1'b1;
    logic arm_n = 1'b0;
    logic clr = 1'b1;
    logic main_hit, dly_hit;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sweep_gate_detect dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_gate_i(main_gate),
        .dly_gate_i (dly_gate),
        .arm_n_i    (arm_n),
        .clr_i      (clr),
        .main_hit_o (main_hit),
        .dly_hit_o  (dly_hit)
    );

    // {req[3:0], main, dly, arm_n, clr, exp_main, exp_dly}; clr is active low
    localparam int NV = 27;
    localparam logic [9:0] VEC [NV] = '{
        {4'd3, 4'b1101, 2'b00},  // R3 rise with no prior fall
        {4'd2, 4'b0101, 2'b00},  // R2 fall primes
        {4'd2, 4'b1101, 2'b10},  // R2 capture
        {4'd5, 4'b0111, 2'b10},  // R5 fall + disarm, still set
        {4'd5, 4'b1111, 2'b10},  // R5 rise, still set
        {4'd6, 4'b1110, 2'b00},  // R6 clear leading edge
        {4'd6, 4'b1111, 2'b00},  // R6 release leaves 0
        {4'd4, 4'b0111, 2'b00},  // R4 fall primes
        {4'd4, 4'b1111, 2'b00},  // R4 rise while disarmed
        {4'd4, 4'b1101, 2'b00},  // R4 arming alone does nothing
        {4'd2, 4'b0101, 2'b00},  // R2 fresh fall
        {4'd2, 4'b1101, 2'b10},  // R2 capture
        {4'd5, 4'b0101, 2'b10},  // R5 fall while captured
        {4'd6, 4'b0100, 2'b00},  // R6 clear, earlier fall discarded
        {4'd6, 4'b0101, 2'b00},  // R6 release
        {4'd6, 4'b1101, 2'b00},  // R6 rise needs fresh fall
        {4'd7, 4'b1100, 2'b00},  // R7 clear edge, held active
        {4'd7, 4'b0100, 2'b00},  // R7 fall during clear
        {4'd7, 4'b1100, 2'b10},  // R7 capture during clear
        {4'd6, 4'b1101, 2'b10},  // R6 release keeps flag
        {4'd8, 4'b1001, 2'b11},  // R8 delayed gate low sets
        {4'd8, 4'b1101, 2'b11},  // R8 holds after gate high
        {4'd9, 4'b1100, 2'b00},  // R9 clear drops both
        {4'd9, 4'b1000, 2'b00},  // R9 held while clear active
        {4'd9, 4'b1001, 2'b01},  // R9 sets after release
        {4'd9, 4'b1100, 2'b00},  // R9 clear
        {4'd9, 4'b1101, 2'b00}   // R9 release with gate high
    };

    task automatic check(input int req, input logic em, input logic ed);
        n_checks++;
        if (main_hit !== em || dly_hit !== ed) begin
            n_fails++;
            $display("FAIL R%0d: main_hit=%b dly_hit=%b expected main_hit=%b dly_hit=%b",
                     req, main_hit, dly_hit, em, ed);
        end
    endtask

    task automatic drive(input logic m, input logic d, input logic a, input logic c);
        @(negedge clk);
        main_gate = m; dly_gate = d; arm_n = a; clr = c;
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 1'b0);              // R1 during reset
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(1, 1'b0, 1'b0);              // R1 after reset release

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            check(int'(VEC[i][9:6]), VEC[i][1], VEC[i][0]);
        end

        // R10: clear edge and capturing rise in the same cycle
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        check(10, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check(10, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check(10, 1'b0, 1'b0);

        // R2 control after R10, then R1 mid-run reset with both flags set
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        drive(1'b1, 1'b0, 1'b0, 1'b1);
        check(2, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 1'b0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule